// File: doc/BRIEF.md
# Frame veto accounting counters

This block keeps the per-run frame and beam intensity tallies. Each frame sync pulse closes one frame interval. Over that interval the block collects every veto source that fired. At the sync it counts the frame as raw. It counts the frame as good only when no collected veto is left unmasked. For a good frame it also adds the frame's protons-per-pulse value to a running total.

Counting normally happens only while a run is active. An active-low override input lets frames be counted while no run is active. A run-start clear input zeroes all tallies and the collected veto state. None of the tallies wrap: each one holds at its all-ones value. The collected veto vector is an output, so the sources that have fired so far in the current frame can be seen.

Top module: `frame_acct`

## Requirements
- R1: After reset, `raw_count`, `good_count`, `ppp_total` and `veto_state` are all zero.
- R2: A cycle with `frame_sync`=1 and `run_active`=1 raises `raw_count` by one, seen on the output one clock later.
- R3: With `run_active`=0 and `count_idle_n`=1, a frame sync changes none of the three tallies. With `run_active`=0 and `count_idle_n`=0, the frame sync is counted exactly as in a run.
- R4: A bit of `veto_state` reads 1 when the matching `veto_in` bit was 1 in any cycle since the previous frame sync or clear. All bits read 0 in the cycle after a frame sync or clear. A veto bit that is high in the frame-sync cycle itself belongs to the frame that is closing.
- R5: A counted frame raises `good_count` by one only when the collected vetoes (`veto_state` OR `veto_in` in the sync cycle), ANDed with the inverse of `veto_ignore`, are all zero.
- R6: A `veto_ignore` bit set to 1 stops the matching veto source from blocking a frame. The mask value that applies is the one in the frame-sync cycle.
- R7: `ppp_total` grows by the `ppp_value` sampled in the frame-sync cycle, and only for counted good frames.
- R8: `run_clear`=1 zeroes all tallies and `veto_state` on the next clock, and it overrides a frame sync in the same cycle.
- R9: `raw_count` and `good_count` hold at all-ones instead of wrapping. `ppp_total` holds at all-ones when a sum would overflow.
- R10: `good_count` never exceeds `raw_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | One-cycle pulse that ends a frame |
| run_active | input | 1 | Run in progress |
| count_idle_n | input | 1 | 0 = count frames even when no run is active |
| run_clear | input | 1 | Run-start clear of all tallies |
| veto_in | input | VETO_W | Veto sources, active high |
| veto_ignore | input | VETO_W | 1 = ignore the matching veto source |
| ppp_value | input | PPP_W | Intensity of the frame, sampled at frame sync |
| raw_count | output | CNT_W | Frames counted |
| good_count | output | CNT_W | Frames counted with no unmasked veto |
| ppp_total | output | SUM_W | Sum of intensity over good frames |
| veto_state | output | VETO_W | Vetoes collected in the current frame |

## Verification
The bench builds the block with narrow widths so that saturation is reached within a short run. Directed cases cover several things:
- a veto pulse in the middle of a frame, which tells the collected state apart from the level seen at the sync;
- a veto only in the sync cycle, which shows which frame that veto belongs to;
- masked and unmasked sources on the same frame;
- frames while idle with the override set and cleared;
- a clear together with a sync.

Random frames then mix the gap lengths, veto densities, masks, run state and intensity values against a reference model. That exposes any error in how the mask is combined, in the good-only adds, or in the point where saturation is reached.

// File: rtl/frame_acct.sv
module frame_acct #(
  parameter int VETO_W = 8,
  parameter int CNT_W  = 32,
  parameter int PPP_W  = 16,
  parameter int SUM_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              run_active,
  input  logic              count_idle_n,
  input  logic              run_clear,
  input  logic [VETO_W-1:0] veto_in,
  input  logic [VETO_W-1:0] veto_ignore,
  input  logic [PPP_W-1:0]  ppp_value,
  output logic [CNT_W-1:0]  raw_count,
  output logic [CNT_W-1:0]  good_count,
  output logic [SUM_W-1:0]  ppp_total,
  output logic [VETO_W-1:0] veto_state
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [SUM_W-1:0] SUM_MAX = {SUM_W{1'b1}};

  logic [VETO_W-1:0] veto_eval;
  logic              blocked, take, take_good;
  logic [SUM_W:0]    sum_ext;

  assign veto_eval = veto_state | veto_in;
  assign blocked   = |(veto_eval & ~veto_ignore);
  assign take      = frame_sync & (run_active | ~count_idle_n);
  assign take_good = take & ~blocked;
  assign sum_ext   = {1'b0, ppp_total} + (SUM_W+1)'(ppp_value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      veto_state <= '0;
    end else if (run_clear || frame_sync) begin
      veto_state <= '0;
    end else begin
      veto_state <= veto_eval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_count  <= '0;
      good_count <= '0;
      ppp_total  <= '0;
    end else if (run_clear) begin
      raw_count  <= '0;
      good_count <= '0;
      ppp_total  <= '0;
    end else begin
      if (take && raw_count != CNT_MAX)
        raw_count <= raw_count + 1'b1;
      if (take_good && good_count != CNT_MAX)
        good_count <= good_count + 1'b1;
      if (take_good)
        ppp_total <= sum_ext[SUM_W] ? SUM_MAX : sum_ext[SUM_W-1:0];
    end
  end

endmodule

module frame_acct_chk #(
  parameter int VETO_W = 8,
  parameter int CNT_W  = 32,
  parameter int SUM_W  = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_sync,
  input logic              run_active,
  input logic              count_idle_n,
  input logic              run_clear,
  input logic [CNT_W-1:0]  raw_count,
  input logic [CNT_W-1:0]  good_count,
  input logic [SUM_W-1:0]  ppp_total,
  input logic [VETO_W-1:0] veto_state
);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_clear |=> (raw_count == '0 && good_count == '0 && ppp_total == '0 && veto_state == '0));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && !run_active && count_idle_n && !run_clear) |=>
      ($stable(raw_count) && $stable(good_count) && $stable(ppp_total)));

  assert_quiet_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_sync && !run_clear) |=>
      ($stable(raw_count) && $stable(good_count) && $stable(ppp_total)));

  assert_sync_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> veto_state == '0);

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_clear |=> (raw_count >= $past(raw_count) && good_count >= $past(good_count)
                    && ppp_total >= $past(ppp_total)));

  assert_good_le_raw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    good_count <= raw_count);

endmodule

bind frame_acct frame_acct_chk #(.VETO_W(VETO_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .run_active(run_active),
  .count_idle_n(count_idle_n), .run_clear(run_clear), .raw_count(raw_count),
  .good_count(good_count), .ppp_total(ppp_total), .veto_state(veto_state)
);

// File: tb/frame_acct_tb_top.sv
module frame_acct_tb_top;
  localparam int VW = 4, CW = 6, PW = 4, SW = 8;

  logic clk = 0, rst_n = 0;
  logic fs = 0, run = 0, idle_n = 1, clr = 0;
  logic [VW-1:0] vin = '0, vign = '0;
  logic [PW-1:0] ppp = '0;
  logic [CW-1:0] raw, good;
  logic [SW-1:0] tot;
  logic [VW-1:0] vst;

  int n_tests = 0, n_fail = 0;
  logic [CW-1:0] m_raw = '0, m_good = '0;
  logic [SW-1:0] m_tot = '0;
  logic [VW-1:0] m_lat = '0;

  always #2 clk = ~clk;

  frame_acct #(.VETO_W(VW), .CNT_W(CW), .PPP_W(PW), .SUM_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_sync(fs), .run_active(run), .count_idle_n(idle_n),
    .run_clear(clr), .veto_in(vin), .veto_ignore(vign), .ppp_value(ppp),
    .raw_count(raw), .good_count(good), .ppp_total(tot), .veto_state(vst));

  function automatic logic [CW-1:0] inc_sat(input logic [CW-1:0] v);
    return (v == {CW{1'b1}}) ? v : v + 1'b1;
  endfunction

  function automatic logic [SW-1:0] add_sat(input logic [SW-1:0] a, input logic [PW-1:0] b);
    logic [SW:0] s;
    s = {1'b0, a} + (SW+1)'(b);
    return s[SW] ? {SW{1'b1}} : s[SW-1:0];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [VW-1:0] ev;
    ev = m_lat | vin;
    if (clr) begin
      m_raw = '0; m_good = '0; m_tot = '0; m_lat = '0;
    end else begin
      if (fs && (run || !idle_n)) begin
        m_raw = inc_sat(m_raw);
        if ((ev & ~vign) == '0) begin
          m_good = inc_sat(m_good);
          m_tot  = add_sat(m_tot, ppp);
        end
      end
      m_lat = fs ? '0 : ev;
    end
  endtask

  task automatic cyc(input logic f, input logic [VW-1:0] v, input string tag);
    fs = f; vin = v;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({tag, " raw"}, 64'(raw), 64'(m_raw));
    chk({tag, " good"}, 64'(good), 64'(m_good));
    chk({tag, " total"}, 64'(tot), 64'(m_tot));
    chk({tag, " veto"}, 64'(vst), 64'(m_lat));
    fs = 0; vin = '0; clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 raw", 64'(raw), 0); chk("R1 good", 64'(good), 0);
    chk("R1 total", 64'(tot), 0); chk("R1 veto", 64'(vst), 0);
    rst_n = 1;
    @(negedge clk);
    run = 1; ppp = 4'd5;
    cyc(1, '0, "R2 clean frame");
    chk("R2 raw is 1", 64'(raw), 1);
    chk("R7 total 5", 64'(tot), 5);
    cyc(0, 4'b0010, "R4 mid pulse");
    chk("R4 latched", 64'(vst), 64'b0010);
    cyc(0, '0, "R4 held");
    cyc(1, '0, "R5 vetoed frame");
    chk("R5 good unchanged", 64'(good), 1);
    chk("R7 no add vetoed", 64'(tot), 5);
    cyc(1, 4'b1000, "R4 sync-cycle veto");
    chk("R4 sync veto blocks", 64'(good), 1);
    vign = 4'b0100;
    cyc(0, 4'b0100, "R6 masked pulse");
    cyc(1, '0, "R6 masked frame");
    chk("R6 good counted", 64'(good), 2);
    vign = '0;
    run = 0; idle_n = 1;
    cyc(1, '0, "R3 idle ignored");
    chk("R3 raw held", 64'(raw), 4);
    idle_n = 0;
    cyc(1, '0, "R3 idle counted");
    chk("R3 raw counted", 64'(raw), 5);
    idle_n = 1; run = 1;
    clr = 1;
    cyc(1, 4'b1111, "R8 clear with sync");
    chk("R8 raw zero", 64'(raw), 0);
    ppp = 4'hF;
    for (int i = 0; i < 70; i++) cyc(1, '0, "R9 saturate");
    chk("R9 raw max", 64'(raw), 63);
    chk("R9 total max", 64'(tot), 255);
    clr = 1;
    cyc(0, '0, "R8 clear");
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [VW-1:0] v;
      v = (($urandom % 4) == 0) ? VW'($urandom) : '0;
      ppp = PW'($urandom);
      if (($urandom % 16) == 0) vign = VW'($urandom);
      if (($urandom % 32) == 0) run = ~run;
      if (($urandom % 32) == 0) idle_n = ~idle_n;
      clr = (($urandom % 200) == 0);
      cyc(($urandom % 3) == 0, v, "R5 R7 random");
      n_tests++;
      if (good > raw) begin
        n_fail++;
        $display("FAIL R10 actual=%0d expected<=%0d", good, raw);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule